// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block steps a four-channel serial transceiver from configuration to a usable link. Software drives a soft-reset bit through a single-bit configuration write port. The bit is guarded by a pairing rule, so that one stray write cannot reset the transceiver or release it. When the reset is released, the sequencer counts microsecond ticks through a fixed settling interval. It then waits for every enabled channel to report PLL lock, up to a programmable limit.

When line coding is on, the sequencer takes over the transmit lanes. It sends a burst of three idle ordered sets, each of four characters and each led by a comma. It then reports the link as up and repeats the burst after a programmable number of cycles. If lock never arrives, an error flag is raised and the sequencer drops back to idle. The SERDES, the PLLs and the encoder sit outside this block. The encoder receives the byte and K-flag pair produced here.

Top module: `link_bringup_seq`

## Requirements
- R1: `softRst` goes from 0 to 1 only on the second of two successive accepted writes of 1, where a write is a cycle with `cfgWrEn` high. Cycles without a write do not break a pair, and a write of the other value does.
- R2: `softRst` goes from 1 to 0 only on the second of two successive writes of 0, and that falling edge starts a bring-up.
- R3: After the release, exactly `SETTLE_TICKS` (3000) `usTick` pulses pass before lock is examined, even if every lock input is already high.
- R4: The sequencer moves on only when every channel whose `chanEn` bit is 1 has its `lockIn` bit at 1. Channels whose `chanEn` bit is 0 are ignored.
- R5: If lock is not reached within `lockLimit` ticks after the settling interval, `linkErr` goes to 1 and the sequencer returns to idle with `linkDone` at 0. `linkErr` clears on the next release.
- R6: With `codingEn` at 1, a burst is 12 consecutive cycles with `txInject` at 1, carrying bytes 0xBC, 0x95, 0xB5, 0xB5 three times over. `txIsK` is 1 only on the 0xBC (K28.5) bytes.
- R7: `linkDone` rises in the cycle after the first burst ends. With `codingEn` at 0, it rises one cycle after lock is seen, and no burst is sent.
- R8: While the link is up, a new burst starts after `syncPeriod` cycles without injection. `linkDone` stays at 1 through the new burst.
- R9: If `softRst` is at 1 while the sequencer is in any state other than idle, the next cycle is idle: `linkDone` is 0 and `txInject` is 0.
- R10: After `rstN` is low, `softRst`, `txInject`, `txIsK`, `linkDone`, `linkErr` and `txByte` are all 0.
- R11: When `txInject` is 0, `txByte` is 0x00 and `txIsK` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe for the soft-reset bit |
| cfgWrData | input | 1 | Value written to the soft-reset bit |
| codingEn | input | 1 | Line coding enabled; when 1, idle bursts are sent |
| chanEn | input | NUM_CH | Channels that take part in the lock decision |
| lockIn | input | NUM_CH | PLL lock flag per channel, 1 = locked |
| usTick | input | 1 | One-cycle pulse every microsecond |
| lockLimit | input | LIMIT_W | Lock timeout in ticks, at least 1 |
| syncPeriod | input | PERIOD_W | Cycles between bursts while the link is up, at least 1 |
| softRst | output | 1 | Soft-reset line to the transceiver |
| txInject | output | 1 | Sequencer owns the transmit lanes |
| txIsK | output | 1 | Current byte is a control character |
| txByte | output | 8 | Byte sent on every transmit lane |
| linkDone | output | 1 | Bring-up complete |
| linkErr | output | 1 | Lock timeout occurred |

## Verification
A wrong settle or timeout count shows up at the ports as a first injected byte or an error edge that arrives one or more cycles away from its computed cycle. The bench checks the exact sampling cycle on each side of these edges. A burst counter that slips shows up within 12 cycles as a wrong byte, a misplaced K-flag or a burst of the wrong length. A pairing filter that fires on a single write shows up on the very next sample of `softRst`. A broken abort path leaves `linkDone` or `txInject` high one cycle after the reset is asserted.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOCKWAIT,
    ST_SYNC,
    ST_UP
  } seq_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrTick;
    logic sendEn;
    logic inUp;
  } seq_cmd_t;

  // datapath -> control events
  typedef struct packed {
    logic relPulse;
    logic settleHit;
    logic limitHit;
    logic burstLast;
    logic periodHit;
  } seq_stat_t;

  localparam int SET_LEN = 4;

  // {isK, byte} for position idx of the idle ordered set
  function automatic logic [8:0] idle_char(input logic [1:0] idx);
    case (idx)
      2'd0:    idle_char = {1'b1, 8'hBC};   // K28.5 comma
      2'd1:    idle_char = {1'b0, 8'h95};   // D21.4
      default: idle_char = {1'b0, 8'hB5};   // D21.5
    endcase
  endfunction

endpackage

// File: rtl/lbs_dpath.sv
module lbs_dpath
  import lbs_pkg::*;
#(
  parameter int SETTLE_TICKS = 3000,
  parameter int SYNC_REPEATS = 3,
  parameter int LIMIT_W      = 16,
  parameter int PERIOD_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgWrData,
  input  logic                usTick,
  input  logic [LIMIT_W-1:0]  lockLimit,
  input  logic [PERIOD_W-1:0] syncPeriod,
  input  seq_cmd_t            cmd,
  output seq_stat_t           stat,
  output logic                softRst,
  output logic                txInject,
  output logic                txIsK,
  output logic [7:0]          txByte
);

  localparam int SETTLE_W   = $clog2(SETTLE_TICKS + 1);
  localparam int CNT_W      = (LIMIT_W > SETTLE_W) ? LIMIT_W : SETTLE_W;
  localparam int BURST_LEN  = SET_LEN * SYNC_REPEATS;
  localparam int BURST_W    = (BURST_LEN > 4) ? $clog2(BURST_LEN) : 2;
  localparam logic [CNT_W-1:0]   SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [BURST_W-1:0] BURST_LAST  = BURST_W'(BURST_LEN - 1);

  // soft-reset pairing filter
  logic prevValid, prevVal, softRstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevVal   <= 1'b0;
      softRstQ  <= 1'b0;
    end else if (cfgWrEn) begin
      prevValid <= 1'b1;
      prevVal   <= cfgWrData;
      if (prevValid && (prevVal == cfgWrData)) softRstQ <= cfgWrData;
    end
  end

  assign softRst = softRstQ;

  // microsecond tick counter, shared by settle and timeout windows
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limitLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (cmd.clrTick) tickCnt <= '0;
    else if (usTick)      tickCnt <= tickCnt + 1'b1;
  end

  assign limitLast = CNT_W'(lockLimit) - 1'b1;

  // burst position counter
  logic [BURST_W-1:0] burstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            burstCnt <= '0;
    else if (!cmd.sendEn) burstCnt <= '0;
    else                  burstCnt <= burstCnt + 1'b1;
  end

  // link-up period counter
  logic [PERIOD_W-1:0] periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          periodCnt <= '0;
    else if (!cmd.inUp) periodCnt <= '0;
    else                periodCnt <= periodCnt + 1'b1;
  end

  always_comb begin
    stat.relPulse  = cfgWrEn && !cfgWrData && prevValid && !prevVal && softRstQ;
    stat.settleHit = usTick && (tickCnt == SETTLE_LAST);
    stat.limitHit  = usTick && (tickCnt == limitLast);
    stat.burstLast = cmd.sendEn && (burstCnt == BURST_LAST);
    stat.periodHit = cmd.inUp && (periodCnt == (syncPeriod - 1'b1));
  end

  // transmit byte stream
  logic [8:0] charSel;

  assign charSel  = idle_char(burstCnt[1:0]);
  assign txInject = cmd.sendEn;
  assign txIsK    = cmd.sendEn & charSel[8];
  assign txByte   = cmd.sendEn ? charSel[7:0] : 8'h00;

  p_rise_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRstQ) |-> $past(cfgWrEn) && $past(cfgWrData));

  p_fall_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(softRstQ) |-> $past(cfgWrEn) && !$past(cfgWrData));

  p_k_comma_r6: assert property (@(posedge clk) disable iff (!rstN)
    txIsK |-> (txByte == 8'hBC) && txInject);

endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              codingEn,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] lockIn,
  input  logic              softRst,
  input  seq_stat_t         stat,
  output seq_cmd_t          cmd,
  output logic              linkDone,
  output logic              linkErr
);

  seq_state_t state, nxtState;
  logic       doneQ, errQ;
  logic       allLocked;

  assign allLocked = &(lockIn | ~chanEn);

  always_comb begin
    nxtState = state;
    case (state)
      ST_IDLE:     if (stat.relPulse) nxtState = ST_SETTLE;
      ST_SETTLE:   if (stat.settleHit) nxtState = ST_LOCKWAIT;
      ST_LOCKWAIT: begin
        if (allLocked)          nxtState = codingEn ? ST_SYNC : ST_UP;
        else if (stat.limitHit) nxtState = ST_IDLE;
      end
      ST_SYNC:     if (stat.burstLast) nxtState = ST_UP;
      ST_UP:       if (stat.periodHit) nxtState = ST_SYNC;
      default:     nxtState = ST_IDLE;
    endcase
    if (state != ST_IDLE && softRst) nxtState = ST_IDLE;
  end

  always_comb begin
    cmd.clrTick = !(state == ST_SETTLE || state == ST_LOCKWAIT)
                  || (state == ST_SETTLE && stat.settleHit);
    cmd.sendEn  = (state == ST_SYNC);
    cmd.inUp    = (state == ST_UP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      state <= nxtState;
      if (nxtState == ST_UP)        doneQ <= 1'b1;
      else if (nxtState != ST_SYNC) doneQ <= 1'b0;
      if (state == ST_IDLE && stat.relPulse)
        errQ <= 1'b0;
      else if (state == ST_LOCKWAIT && !allLocked && stat.limitHit && !softRst)
        errQ <= 1'b1;
    end
  end

  assign linkDone = doneQ;
  assign linkErr  = errQ;

  p_settle_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKWAIT && $past(state) != ST_LOCKWAIT) |-> $past(stat.settleHit));

  p_err_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(state) == ST_LOCKWAIT);

  p_burst_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_SYNC && state == ST_UP) |-> $past(stat.burstLast));

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !errQ);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && state != ST_IDLE) |=> (state == ST_IDLE) && !doneQ);

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int SETTLE_TICKS = 3000,
  parameter int SYNC_REPEATS = 3,
  parameter int LIMIT_W      = 16,
  parameter int PERIOD_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgWrData,
  input  logic                codingEn,
  input  logic [NUM_CH-1:0]   chanEn,
  input  logic [NUM_CH-1:0]   lockIn,
  input  logic                usTick,
  input  logic [LIMIT_W-1:0]  lockLimit,
  input  logic [PERIOD_W-1:0] syncPeriod,
  output logic                softRst,
  output logic                txInject,
  output logic                txIsK,
  output logic [7:0]          txByte,
  output logic                linkDone,
  output logic                linkErr
);

  seq_cmd_t  cmd;
  seq_stat_t stat;

  lbs_dpath #(
    .SETTLE_TICKS(SETTLE_TICKS),
    .SYNC_REPEATS(SYNC_REPEATS),
    .LIMIT_W(LIMIT_W),
    .PERIOD_W(PERIOD_W)
  ) uDpath (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .usTick(usTick), .lockLimit(lockLimit), .syncPeriod(syncPeriod),
    .cmd(cmd), .stat(stat),
    .softRst(softRst), .txInject(txInject), .txIsK(txIsK), .txByte(txByte)
  );

  lbs_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .codingEn(codingEn), .chanEn(chanEn), .lockIn(lockIn),
    .softRst(softRst), .stat(stat), .cmd(cmd),
    .linkDone(linkDone), .linkErr(linkErr)
  );

endmodule

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgWrData = 1'b0, codingEn = 1'b1, usTick = 1'b1;
  logic [3:0]  chanEn = 4'hF, lockIn = 4'hF;
  logic [15:0] lockLimit = 16'd100, syncPeriod = 16'd20;
  logic        softRst, txInject, txIsK, linkDone, linkErr;
  logic [7:0]  txByte;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .codingEn(codingEn), .chanEn(chanEn), .lockIn(lockIn), .usTick(usTick),
    .lockLimit(lockLimit), .syncPeriod(syncPeriod), .softRst(softRst),
    .txInject(txInject), .txIsK(txIsK), .txByte(txByte),
    .linkDone(linkDone), .linkErr(linkErr)
  );

  // {wrEn, data, expected softRst}
  localparam logic [2:0] WR_VEC [11] = '{
    3'b110,  // first 1: no change (R1)
    3'b010,  // idle cycle keeps the pair open
    3'b111,  // second 1 asserts (R1)
    3'b101,  // single 0 holds (R2)
    3'b111,  // 1 breaks the 0 pair
    3'b101,
    3'b100,  // second 0 releases (R2)
    3'b110,
    3'b100,
    3'b110,
    3'b111   // pair of 1 asserts again (R1)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeBit(input logic v);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic release_rst();
    writeBit(1'b0);
    writeBit(1'b0);
  endtask

  task automatic assert_rst();
    writeBit(1'b1);
    writeBit(1'b1);
  endtask

  function automatic logic [8:0] expChar(input int i);
    case (i % 4)
      0:       return {1'b1, 8'hBC};
      1:       return {1'b0, 8'h95};
      default: return {1'b0, 8'hB5};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 softRst", softRst, 0);
    check("R10 outputs", {txInject, txIsK, linkDone, linkErr}, 0);
    check("R10 txByte", txByte, 0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table for the pairing filter
    for (int i = 0; i < 11; i++) begin
      cfgWrEn = WR_VEC[i][2];
      cfgWrData = WR_VEC[i][1];
      @(negedge clk);
      cfgWrEn = 1'b0;
      check($sformatf("R1/R2 vec%0d softRst", i), softRst, WR_VEC[i][0]);
    end
    check("R9 idle after abort", {linkDone, txInject}, 0);

    // full bring-up with coding
    release_rst();
    repeat (SETTLE) @(negedge clk);
    check("R3 no burst before settle end", txInject, 0);
    check("R11 quiet byte", {txIsK, txByte}, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check($sformatf("R6 inject %0d", i), txInject, 1);
      check($sformatf("R6 char %0d", i), {txIsK, txByte}, expChar(i));
    end
    check("R7 done low during first burst", linkDone, 0);
    @(negedge clk);
    check("R7 done after burst", linkDone, 1);
    check("R11 idle lanes", {txInject, txIsK, txByte}, 0);
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      check("R8 gap", {txInject, linkDone}, 2'b01);
    end
    @(negedge clk);
    check("R8 repeat burst", {txInject, txIsK, txByte}, {2'b11, 8'hBC});
    check("R8 done held", linkDone, 1);
    assert_rst();
    check("R1 softRst reasserted", softRst, 1);
    @(negedge clk);
    check("R9 abort clears", {linkDone, txInject}, 0);

    // no coding, one channel disabled and unlocked
    codingEn = 1'b0;
    chanEn = 4'b0111;
    lockIn = 4'b0111;
    release_rst();
    repeat (SETTLE) @(negedge clk);
    check("R4 not done in settle", linkDone, 0);
    @(negedge clk);
    check("R4 disabled channel ignored", linkDone, 1);
    check("R7 no burst without coding", txInject, 0);
    assert_rst();
    @(negedge clk);

    // timeout
    codingEn = 1'b1;
    chanEn = 4'hF;
    lockIn = 4'b1011;
    lockLimit = 16'd10;
    release_rst();
    repeat (SETTLE + 9) @(negedge clk);
    check("R5 err before limit", linkErr, 0);
    @(negedge clk);
    check("R5 err at limit", linkErr, 1);
    check("R5 not done", {linkDone, txInject}, 0);
    repeat (5) @(negedge clk);
    check("R4 partial lock never proceeds", {linkDone, txInject}, 0);
    assert_rst();
    check("R5 err held in idle", linkErr, 1);
    release_rst();
    check("R5 err cleared on release", linkErr, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule